// File: doc/BRIEF.md
# Nibble-Multiplexed Sample Bus Interface

This block moves converter samples between a data-converter core and a signal processor over a 4-bit parallel bus. The bus runs at four nibble periods per sample word. Each 16-bit word is spread across the four lanes in bit-interleaved order, so lane k carries bits k, k+4, k+8 and k+12 in successive nibble periods, least significant nibble first. The block produces the bus timing itself. A word strobe is high during the first nibble of every word. A separate nibble clock is held low in the normal mode and toggles in a half-rate mode, where every nibble period lasts two master clock cycles.

On the receive side, a signed converter code is clamped to the 13-bit signed range and left-justified into a 16-bit word with zero fill. It then passes through a five-word delay that models the converter latency before it is serialized. On the transmit side, nibbles are gathered into a 16-bit word aligned to the word strobe. The top 12 bits are presented to the core one word period later.

A power-down input freezes transmit capture and drives the receive lanes low. A loopback input replaces converter data on the receive bus with the most recently assembled transmit word.

Top module: `nibble_bus_if`

## Requirements
- R1: While `rst_n` is low, `word_clk` and `nib_clk` are both 1. Directly after reset, `rx_nib` and `tx_sample` are 0.
- R2: `word_clk` is 1 for exactly the first nibble period of every four and 0 for the other three. Counting starts with the first cycle after reset release.
- R3: With `osr2`=0, `nib_clk` is 0 and each nibble period is one clock cycle. With `osr2`=1, each nibble period is two cycles and `nib_clk` is 1 in the first cycle and 0 in the second.
- R4: In nibble period n (0..3) of a word, `rx_nib[k]` carries bit 4n+k of the outgoing 16-bit receive word.
- R5: `tx_nib[k]` in nibble period n is taken as bit 4n+k of a transmit word. It is registered at the clock edge that ends the period. `tx_sample` is bits [15:4] of that word.
- R6: A transmit word completed at the end of word j appears on `tx_sample` after the end of word j+1 and holds until the next word end.
- R7: The receive word is the 14-bit two's-complement `rx_code` clamped to the range -4096..4095, placed in bits [15:3], with bits [2:0] zero.
- R8: `rx_code` is sampled at the edge that ends word j. With loopback off, its formatted value is sent on `rx_nib` during word j+5.
- R9: In a word with `pdown`=1, `rx_nib` is 0 and the transmit nibbles are ignored. `tx_sample` and the loopback word keep their values, and `word_clk` keeps its pattern.
- R10: With `loopback`=1 and `pdown`=0, the word sent on `rx_nib` during word j+1 is the transmit word last completed without power-down, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master bus clock |
| rst_n | input | 1 | Active-low reset |
| osr2 | input | 1 | 1 selects the half-rate mode |
| pdown | input | 1 | Power-down: freezes transmit capture, receive lanes low |
| loopback | input | 1 | Send the transmit word back on the receive lanes |
| rx_code | input | 14 | Signed converter code from the core |
| tx_sample | output | 12 | Transmit sample to the core |
| tx_nib | input | 4 | Transmit nibble lanes from the processor |
| rx_nib | output | 4 | Receive nibble lanes to the processor |
| word_clk | output | 1 | Word strobe, high in the first nibble of a word |
| nib_clk | output | 1 | Nibble clock, toggling only in half-rate mode |

## Verification
The assertions assume that `osr2` changes only while reset is held. They also assume that `pdown` and `loopback` change only at word boundaries, so a word is never partly powered down. The bench enforces this by construction. A mode is selected before reset is released. The driver task sets `pdown`, `loopback` and `rx_code` once, at the start of each word, and then spends exactly four nibble periods on the lanes before it returns. The monitor samples one time unit after the falling edge, so it never races the driver.

// File: rtl/nibble_bus_if.sv
`timescale 1ns/1ps
module nibble_bus_if #(
  parameter int CODE_W   = 14,
  parameter int SAMPLE_W = 13,
  parameter int WORD_W   = 16,
  parameter int LANES    = 4,
  parameter int TX_W     = 12,
  parameter int RX_LAT   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osr2,
  input  logic              pdown,
  input  logic              loopback,
  input  logic [CODE_W-1:0] rx_code,
  output logic [TX_W-1:0]   tx_sample,
  input  logic [LANES-1:0]  tx_nib,
  output logic [LANES-1:0]  rx_nib,
  output logic              word_clk,
  output logic              nib_clk
);
  localparam int NIBS  = WORD_W / LANES;
  localparam int IDX_W = $clog2(NIBS);
  localparam int PAD   = WORD_W - SAMPLE_W;
  localparam logic signed [CODE_W-1:0] HI = CODE_W'((1 << (SAMPLE_W-1)) - 1);
  localparam logic signed [CODE_W-1:0] LO = CODE_W'(-(1 << (SAMPLE_W-1)));

  logic [IDX_W-1:0]  idx;
  logic              ph;
  logic [WORD_W-1:0] tx_buf, lb_word;
  logic [TX_W-1:0]   tx_pend;
  logic [WORD_W-1:0] pipe [RX_LAT];

  wire adv      = !osr2 || ph;
  wire word_end = adv && (idx == IDX_W'(NIBS-1));
  wire [WORD_W-1:0] tx_word = {tx_nib, tx_buf[WORD_W-LANES-1:0]};

  logic signed [CODE_W-1:0] code_s;
  logic [SAMPLE_W-1:0]      sat;
  assign code_s = $signed(rx_code);
  always_comb begin
    if (code_s > HI)      sat = HI[SAMPLE_W-1:0];
    else if (code_s < LO) sat = LO[SAMPLE_W-1:0];
    else                  sat = rx_code[SAMPLE_W-1:0];
  end
  wire [WORD_W-1:0] fmt_word = {sat, {PAD{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      ph  <= 1'b0;
    end else begin
      ph <= osr2 ? ~ph : 1'b0;
      if (adv) idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf    <= '0;
      tx_pend   <= '0;
      tx_sample <= '0;
      lb_word   <= '0;
    end else if (!pdown) begin
      if (adv) tx_buf[int'(idx)*LANES +: LANES] <= tx_nib;
      if (word_end) begin
        tx_sample <= tx_pend;
        tx_pend   <= tx_word[WORD_W-1 -: TX_W];
        lb_word   <= tx_word;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RX_LAT; i++) pipe[i] <= '0;
    end else if (word_end) begin
      pipe[0] <= fmt_word;
      for (int i = 1; i < RX_LAT; i++) pipe[i] <= pipe[i-1];
    end
  end

  wire [WORD_W-1:0] rx_sel = loopback ? lb_word : pipe[RX_LAT-1];
  assign rx_nib   = pdown ? '0 : rx_sel[int'(idx)*LANES +: LANES];
  assign word_clk = !rst_n || (idx == '0);
  assign nib_clk  = !rst_n || (osr2 && !ph);

  p_strobe_one_nibble_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!osr2 && word_clk) |=> !word_clk);
  p_strobe_two_cycles_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (osr2 && $rose(word_clk)) |=> word_clk);
  p_nibclk_ground_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !osr2 |-> !nib_clk);
  p_nibclk_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (osr2 && $past(rst_n)) |-> (nib_clk != $past(nib_clk)));
  p_low_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pdown && !loopback && idx == '0) |-> (rx_nib[PAD-1:0] == '0));
  p_pdown_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pdown |=> $stable(tx_sample));
endmodule

// File: tb/nibble_bus_if_bench.sv
`timescale 1ns/1ps
module nibble_bus_if_bench;
  logic clk = 0, rst_n = 0, osr2 = 0, pdown = 0, loopback = 0;
  logic [13:0] rx_code = '0;
  logic [3:0]  tx_nib = '0;
  logic [11:0] tx_sample;
  logic [3:0]  rx_nib;
  logic        word_clk, nib_clk;

  nibble_bus_if u_nibble_bus_if (
    .clk(clk), .rst_n(rst_n), .osr2(osr2), .pdown(pdown), .loopback(loopback),
    .rx_code(rx_code), .tx_sample(tx_sample), .tx_nib(tx_nib), .rx_nib(rx_nib),
    .word_clk(word_clk), .nib_clk(nib_clk));

  always #2.5 clk = ~clk;

  typedef struct { int due; logic [15:0] val; } item_t;
  item_t rx_q[$], lb_q[$], tx_q[$];
  int checks = 0, errors = 0, wj = 0, m = 1;
  bit done = 0;
  logic [15:0] pend_m, lb_m;
  logic [11:0] samp_m;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] fmt(logic [13:0] c);
    int v = int'($signed(c));
    logic [31:0] u;
    if (v > 4095) v = 4095;
    if (v < -4096) v = -4096;
    u = v;
    return {u[12:0], 3'b000};
  endfunction

  function automatic logic [13:0] code_for(int j);
    case (j)
      0: return 14'h1FFF; 1: return 14'h2000; 2: return 14'h0FFF; 3: return 14'h3000;
      4: return 14'h1000; 5: return 14'h2FFF; 6: return 14'h0005; 7: return 14'h3FFF;
      default: return 14'((j * 613) ^ 14'h0A5A);
    endcase
  endfunction

  task automatic send_word(logic [15:0] tw, logic [13:0] code, logic pd, logic lb);
    pdown = pd; loopback = lb; rx_code = code;
    for (int n = 0; n < 4; n++) begin
      tx_nib = tw[n*4 +: 4];
      repeat (m) @(negedge clk);
    end
    rx_q.push_back('{due: wj + 5, val: fmt(code)});
    if (!pd) begin samp_m = pend_m[15:4]; pend_m = tw; lb_m = tw; end
    lb_q.push_back('{due: wj + 1, val: lb_m});
    tx_q.push_back('{due: wj + 1, val: {4'h0, samp_m}});
    wj++;
  endtask

  task automatic mon(int nw);
    for (int w = 0; w < nw; w++) begin
      logic [15:0] got = '0, exp = '0;
      logic pd = 0, lb = 0;
      for (int c = 0; c < 4*m; c++) begin
        int n = c / m;
        #1;
        if (c == 0) begin
          logic [11:0] te = '0;
          pd = pdown; lb = loopback;
          while (tx_q.size() > 0 && tx_q[0].due < w) void'(tx_q.pop_front());
          if (tx_q.size() > 0 && tx_q[0].due == w) te = tx_q[0].val[11:0];
          chk(w == 0 ? "R1 tx_sample after reset" : "R5 R6 R9 tx_sample", int'(tx_sample), int'(te));
        end
        chk("R2 word_clk", int'(word_clk), int'(n == 0));
        chk("R3 nib_clk", int'(nib_clk), int'(osr2 && (c % m == 0)));
        if (c % m == 0) got[n*4 +: 4] = rx_nib;
        @(negedge clk);
      end
      while (rx_q.size() > 0 && rx_q[0].due < w) void'(rx_q.pop_front());
      while (lb_q.size() > 0 && lb_q[0].due < w) void'(lb_q.pop_front());
      if (pd) exp = '0;
      else if (lb) exp = (lb_q.size() > 0 && lb_q[0].due == w) ? lb_q[0].val : 16'h0;
      else exp = (rx_q.size() > 0 && rx_q[0].due == w) ? rx_q[0].val : 16'h0;
      chk(pd ? "R9 rx lanes in power-down" : lb ? "R10 R4 loopback word" : "R4 R7 R8 rx word",
          int'(got), int'(exp));
    end
  endtask

  task automatic run_phase(logic half, int nw, int pd_lo, int pd_hi, int lb_lo, int lb_hi);
    rst_n = 0; osr2 = half; m = half ? 2 : 1;
    pdown = 0; loopback = 0; tx_nib = '0;
    rx_q.delete(); lb_q.delete(); tx_q.delete();
    wj = 0; pend_m = '0; lb_m = '0; samp_m = '0;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 word_clk in reset", int'(word_clk), 1);
    chk("R1 nib_clk in reset", int'(nib_clk), 1);
    chk("R1 rx_nib in reset", int'(rx_nib), 0);
    @(negedge clk);
    rst_n = 1;
    fork
      for (int j = 0; j < nw; j++)
        send_word(16'hA5C3 ^ 16'(j * 16'h1357), code_for(j),
                  (j >= pd_lo && j <= pd_hi), (j >= lb_lo && j <= lb_hi));
      mon(nw);
    join
  endtask

  initial begin
    run_phase(1'b0, 25, 10, 12, 13, 17);
    run_phase(1'b1, 14, 6, 6, 7, 10);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog timeout");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule